// File: doc/BRIEF.md
# Interrupt Mask and Priority Bank

This block decides which interrupt source lines may reach the processor and at which level, then picks a single winner. Software programs it through a small register bus: an address, a write strobe, write data and combinational read data. The bank holds one enable bit per source, kept in one of three register styles chosen by parameter, and one priority field per source, kept in one of two register styles. Each cycle the block looks at the pending lines and raises a request for the highest-priority source that is pending and allowed through. It also reports that source's index and level.

Both the mask bits and the priority fields are packed from the most significant end of a register. Source 0 therefore owns the top bit or the top field, and this layout holds for 8, 16 and 32 bit registers. A source can be held off in two ways: by its mask bit, or by a priority of zero. Priority-clear writes and zero-level writes both produce a level of zero. A level of one is never stored, so the lowest usable level is two.

The address map is fixed by the parameters. With NMR = ceil(NUM_SRC/REG_W) mask words, SPR = REG_W/PRIO_W fields per priority word and NPR = ceil(NUM_SRC/SPR) priority words:

| Region | Address range |
|---|---|
| Mask (or mask-set) words | 0 .. NMR-1 |
| Mask-clear words | NMR .. 2*NMR-1 |
| Priority (or priority-set) words | 2*NMR .. 2*NMR+NPR-1 |
| Priority-clear words | 2*NMR+NPR .. 2*NMR+2*NPR-1 |

Top module: `irq_gate_bank`

## Requirements
- R1: After reset every source is masked and has level 0. `irq_req`, `win_id` and `win_prio` are 0. A mask word reads back 0 in enable style, and 1 for every existing source bit in the block and pair styles. Priority words read 0.
- R2: Source s has its mask bit in mask word s/REG_W, at bit REG_W-1-(s mod REG_W), so source 0 is the top bit.
- R3: In enable style (MASK_STYLE 0), a write to a mask word stores the data, and a 1 bit lets that source through. In block style (MASK_STYLE 1), a write stores the data and a 1 bit holds that source off. A read returns the word in the same sense.
- R4: In pair style (MASK_STYLE 2), writing a 1 to a bit of the mask-set word masks that source. Writing a 1 to a bit of the mask-clear word unmasks it. A 0 bit in either write leaves its source unchanged. Reading either word returns the mask state, with 1 meaning masked.
- R5: Source s has its level field in priority word s/SPR, at bits [REG_W-(j+1)*PRIO_W +: PRIO_W] with j = s mod SPR. Register bits outside all fields read 0.
- R6: In single-register priority style (PRIO_STYLE 0), a write stores each field of the addressed word. A field value of 0 disables that source. A field value of 1 is ignored and the old level is kept.
- R7: In pair priority style (PRIO_STYLE 1), a field of 2 or more in a priority-set write becomes that source's level. A field of 0 or 1 in a set write changes nothing. An all-ones field in a priority-clear write sets the level to 0, and any other field value changes nothing. Reading either word returns the levels.
- R8: `irq_req` is 1 when at least one source is pending, unmasked and at a nonzero level. The winner is the highest level, and a tie goes to the lowest index. With no request, `win_id` and `win_prio` are 0.
- R9: The outputs are registered. A change on `src_pend` before clock edge N is visible after edge N. A register write sampled at edge N is visible after edge N+1.
- R10: The same layout rules hold for REG_W of 8, 16 and 32, including field widths that do not divide the register width.
- R11: In enable and block styles, writes to the mask-clear address have no effect and the address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | REG_W | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | REG_W | Read data for `bus_addr`; combinational, 0 for unmapped addresses |
| src_pend | input | NUM_SRC | Pending level of each source |
| irq_req | output | 1 | Request to the processor |
| win_id | output | IDX_W | Index of the winning source |
| win_prio | output | PRIO_W | Level of the winning source |

## Verification
A flipped mask bit or a corrupted level field changes which source wins, or whether `irq_req` rises, one edge after the pending pattern is applied. The bench shows this by arranging ties and masked higher-level sources so that each wrong bit picks a different index. A field decoded at the wrong position shows up at once on read-back, because every stored word is visible on `bus_rdata` in the cycle after the write. Stale output registers show up as a one-cycle lag that the bench samples edge by edge.

// File: rtl/igb_pkg.sv
package igb_pkg;

    typedef enum logic [1:0] {
        MSK_ENABLE = 2'd0,
        MSK_BLOCK  = 2'd1,
        MSK_PAIR   = 2'd2
    } mask_style_e;

    typedef enum logic {
        PRI_RMW  = 1'b0,
        PRI_PAIR = 1'b1
    } prio_style_e;

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/igb_mask_regs.sv
module igb_mask_regs
    import igb_pkg::*;
#(
    parameter int          NUM_SRC    = 8,
    parameter int          REG_W      = 8,
    parameter int          ADDR_W     = 4,
    parameter mask_style_e MASK_STYLE = MSK_ENABLE,
    parameter int          SET_BASE   = 0,
    parameter int          CLR_BASE   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic               we,
    output logic [NUM_SRC-1:0] src_en,
    output logic [REG_W-1:0]   rd_data
);

    localparam bit HAS_CLR = (MASK_STYLE == MSK_PAIR);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mstate_t;

    mstate_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] word_addr(int base, int s);
        return ADDR_W'(base + s / REG_W);
    endfunction

    function automatic int bit_pos(int s);
        return REG_W - 1 - (s % REG_W);
    endfunction

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            // read view: enable style shows pass bits, the others show block bits
            if (addr == word_addr(SET_BASE, s) || (HAS_CLR && addr == word_addr(CLR_BASE, s))) begin
                rd_data[bit_pos(s)] = (MASK_STYLE == MSK_ENABLE) ? st_q.en[s] : ~st_q.en[s];
            end
            if (we && addr == word_addr(SET_BASE, s)) begin
                case (MASK_STYLE)
                    MSK_ENABLE: st_d.en[s] = wdata[bit_pos(s)];
                    MSK_BLOCK:  st_d.en[s] = ~wdata[bit_pos(s)];
                    default: begin
                        if (wdata[bit_pos(s)]) st_d.en[s] = 1'b0;
                    end
                endcase
            end
            if (HAS_CLR && we && addr == word_addr(CLR_BASE, s) && wdata[bit_pos(s)]) begin
                st_d.en[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_en = st_q.en;

endmodule

// File: rtl/igb_prio_regs.sv
module igb_prio_regs
    import igb_pkg::*;
#(
    parameter int          NUM_SRC    = 8,
    parameter int          REG_W      = 8,
    parameter int          PRIO_W     = 4,
    parameter int          ADDR_W     = 4,
    parameter prio_style_e PRIO_STYLE = PRI_RMW,
    parameter int          SET_BASE   = 2,
    parameter int          CLR_BASE   = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    input  logic                            we,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  level,
    output logic [REG_W-1:0]                rd_data
);

    localparam int SPR     = REG_W / PRIO_W;
    localparam bit HAS_CLR = (PRIO_STYLE == PRI_PAIR);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] lvl;
    } pstate_t;

    pstate_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] word_addr(int base, int s);
        return ADDR_W'(base + s / SPR);
    endfunction

    function automatic int fld_lsb(int s);
        return REG_W - ((s % SPR) + 1) * PRIO_W;
    endfunction

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (addr == word_addr(SET_BASE, s) || (HAS_CLR && addr == word_addr(CLR_BASE, s))) begin
                rd_data[fld_lsb(s) +: PRIO_W] = st_q.lvl[s];
            end
            // level one is never stored; pair style also skips zero fields
            if (we && addr == word_addr(SET_BASE, s)
                && wdata[fld_lsb(s) +: PRIO_W] != PRIO_W'(1)
                && (!HAS_CLR || wdata[fld_lsb(s) +: PRIO_W] != '0)) begin
                st_d.lvl[s] = wdata[fld_lsb(s) +: PRIO_W];
            end
            if (HAS_CLR && we && addr == word_addr(CLR_BASE, s)
                && &wdata[fld_lsb(s) +: PRIO_W]) begin
                st_d.lvl[s] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;

endmodule

// File: rtl/igb_pick.sv
module igb_pick #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             src_en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] level,
    output logic                           req,
    output logic [IDX_W-1:0]               id,
    output logic [PRIO_W-1:0]              lvl
);

    typedef struct packed {
        logic              req;
        logic [IDX_W-1:0]  id;
        logic [PRIO_W-1:0] lvl;
    } pick_t;

    pick_t pk_d, pk_q;

    always_comb begin
        pk_d = '0;
        // strict compare keeps the lowest index on a tie
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pend[s] && src_en[s] && level[s] > pk_d.lvl) begin
                pk_d.lvl = level[s];
                pk_d.id  = IDX_W'(s);
            end
        end
        pk_d.req = |pk_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign req = pk_q.req;
    assign id  = pk_q.id;
    assign lvl = pk_q.lvl;

endmodule

// File: rtl/irq_gate_bank.sv
module irq_gate_bank
    import igb_pkg::*;
#(
    parameter int          NUM_SRC    = 8,
    parameter int          REG_W      = 8,
    parameter int          PRIO_W     = 4,
    parameter int          ADDR_W     = 4,
    parameter mask_style_e MASK_STYLE = MSK_ENABLE,
    parameter prio_style_e PRIO_STYLE = PRI_RMW,
    parameter int          IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_we,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_pend,
    output logic               irq_req,
    output logic [IDX_W-1:0]   win_id,
    output logic [PRIO_W-1:0]  win_prio
);

    localparam int NMR       = ceil_div(NUM_SRC, REG_W);
    localparam int SPR       = REG_W / PRIO_W;
    localparam int NPR       = ceil_div(NUM_SRC, SPR);
    localparam int MSET_BASE = 0;
    localparam int MCLR_BASE = NMR;
    localparam int PSET_BASE = 2 * NMR;
    localparam int PCLR_BASE = 2 * NMR + NPR;

    logic [NUM_SRC-1:0]             src_en;
    logic [NUM_SRC-1:0][PRIO_W-1:0] level;
    logic [REG_W-1:0]               mask_rd;
    logic [REG_W-1:0]               prio_rd;

    igb_mask_regs #(
        .NUM_SRC    (NUM_SRC),
        .REG_W      (REG_W),
        .ADDR_W     (ADDR_W),
        .MASK_STYLE (MASK_STYLE),
        .SET_BASE   (MSET_BASE),
        .CLR_BASE   (MCLR_BASE)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .src_en  (src_en),
        .rd_data (mask_rd)
    );

    igb_prio_regs #(
        .NUM_SRC    (NUM_SRC),
        .REG_W      (REG_W),
        .PRIO_W     (PRIO_W),
        .ADDR_W     (ADDR_W),
        .PRIO_STYLE (PRIO_STYLE),
        .SET_BASE   (PSET_BASE),
        .CLR_BASE   (PCLR_BASE)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .level   (level),
        .rd_data (prio_rd)
    );

    igb_pick #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (src_pend),
        .src_en (src_en),
        .level  (level),
        .req    (irq_req),
        .id     (win_id),
        .lvl    (win_prio)
    );

    // address regions never overlap, so an OR merges the two read paths
    assign bus_rdata = mask_rd | prio_rd;

endmodule

// File: rtl/igb_checker.sv
module igb_checker #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [NUM_SRC-1:0] src_pend,
    input logic               irq_req,
    input logic [IDX_W-1:0]   win_id,
    input logic [PRIO_W-1:0]  win_prio
);

    logic [NUM_SRC-1:0] pend_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_seen <= '0;
        end else begin
            pend_seen <= src_pend;
        end
    end

    // R8: nothing pending means no request one edge later
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend == '0) |=> !irq_req);

    // R8: the reported winner was pending when it was chosen
    a_r8_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend_seen[win_id]);

    // R8: without a request the winner fields rest at zero
    a_r8_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (win_id == '0 && win_prio == '0));

    // R6 / R7: a granted level is never below two
    a_r6_no_level_one: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (win_prio > PRIO_W'(1)));

    // R9: with no write and steady inputs the registered result holds
    a_r9_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_we) && $stable(src_pend)) |=> ($stable(win_id) && $stable(win_prio) && $stable(irq_req)));

endmodule

bind irq_gate_bank igb_checker #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .src_pend (src_pend),
    .irq_req  (irq_req),
    .win_id   (win_id),
    .win_prio (win_prio)
);

// File: tb/sim_irq_gate_bank.sv
module sim_irq_gate_bank;
    import igb_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       we;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] pend;
        logic       irq;
        logic [2:0] id;
        logic [3:0] prio;
    } vec_t;

    // unit 0: enable-style mask at address 0, levels at 2..5 (two per word)
    localparam vec_t TBL [10] = '{
        '{1'b1, 4'd0, 8'hFF, 8'h00, 1'b0, 3'd0, 4'd0},  // R8 no pending
        '{1'b1, 4'd2, 8'h35, 8'h03, 1'b1, 3'd1, 4'd5},  // R8 higher level wins
        '{1'b1, 4'd3, 8'h55, 8'h0C, 1'b1, 3'd2, 4'd5},  // R8 tie -> lower index
        '{1'b1, 4'd0, 8'h7F, 8'h01, 1'b0, 3'd0, 4'd0},  // R2 top bit holds source 0
        '{1'b1, 4'd5, 8'h0F, 8'h81, 1'b1, 3'd7, 4'hF},  // R3 masked s0, s7 passes
        '{1'b1, 4'd0, 8'hFE, 8'h81, 1'b1, 3'd0, 4'd3},  // R3 bit 0 holds source 7
        '{1'b1, 4'd2, 8'h15, 8'h01, 1'b1, 3'd0, 4'd3},  // R6 level 1 ignored
        '{1'b1, 4'd2, 8'h05, 8'h01, 1'b0, 3'd0, 4'd0},  // R6 level 0 disables
        '{1'b1, 4'd4, 8'h2F, 8'h30, 1'b1, 3'd5, 4'hF},  // R5 second field of word
        '{1'b0, 4'd0, 8'h00, 8'h10, 1'b1, 3'd4, 4'd2}   // R6 level 2 usable
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we0 = 1'b0, we1 = 1'b0, we2 = 1'b0;
    logic [7:0]  pend = '0;

    logic [7:0]  rd0;
    logic [15:0] rd1;
    logic [31:0] rd2;
    logic        irq0, irq1, irq2;
    logic [2:0]  id0, id1, id2;
    logic [3:0]  pr0, pr1;
    logic [4:0]  pr2;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_gate_bank #(.NUM_SRC(8), .REG_W(8), .PRIO_W(4), .ADDR_W(4),
                    .MASK_STYLE(MSK_ENABLE), .PRIO_STYLE(PRI_RMW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata[7:0]),
        .bus_we(we0), .bus_rdata(rd0), .src_pend(pend),
        .irq_req(irq0), .win_id(id0), .win_prio(pr0));

    irq_gate_bank #(.NUM_SRC(8), .REG_W(16), .PRIO_W(4), .ADDR_W(4),
                    .MASK_STYLE(MSK_BLOCK), .PRIO_STYLE(PRI_PAIR)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata[15:0]),
        .bus_we(we1), .bus_rdata(rd1), .src_pend(pend),
        .irq_req(irq1), .win_id(id1), .win_prio(pr1));

    irq_gate_bank #(.NUM_SRC(8), .REG_W(32), .PRIO_W(5), .ADDR_W(4),
                    .MASK_STYLE(MSK_PAIR), .PRIO_STYLE(PRI_RMW)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we2), .bus_rdata(rd2), .src_pend(pend),
        .irq_req(irq2), .win_id(id2), .win_prio(pr2));

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(int unit, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        case (unit)
            0: we0 = 1'b1;
            1: we1 = 1'b1;
            default: we2 = 1'b1;
        endcase
        @(negedge clk);
        we0 = 1'b0;
        we1 = 1'b0;
        we2 = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic rd(int unit, logic [3:0] a, logic [31:0] exp, string req);
        logic [31:0] act;
        addr = a;
        #1;
        case (unit)
            0: act = {24'h0, rd0};
            1: act = {16'h0, rd1};
            default: act = rd2;
        endcase
        check(req, $sformatf("read u%0d addr %0d", unit, a), act, exp);
    endtask

    task automatic out(int unit, logic irq, logic [2:0] id, logic [4:0] pr, string req);
        case (unit)
            0: begin
                check(req, "u0 irq", {31'h0, irq0}, {31'h0, irq});
                check(req, "u0 id", {29'h0, id0}, {29'h0, id});
                check(req, "u0 prio", {28'h0, pr0}, {27'h0, pr});
            end
            1: begin
                check(req, "u1 irq", {31'h0, irq1}, {31'h0, irq});
                check(req, "u1 id", {29'h0, id1}, {29'h0, id});
                check(req, "u1 prio", {28'h0, pr1}, {27'h0, pr});
            end
            default: begin
                check(req, "u2 irq", {31'h0, irq2}, {31'h0, irq});
                check(req, "u2 id", {29'h0, id2}, {29'h0, id});
                check(req, "u2 prio", {27'h0, pr2}, {27'h0, pr});
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of all three variants
        out(0, 1'b0, 3'd0, 5'd0, "R1");
        out(1, 1'b0, 3'd0, 5'd0, "R1");
        out(2, 1'b0, 3'd0, 5'd0, "R1");
        rd(0, 4'd0, 32'h0000_0000, "R1");
        rd(1, 4'd0, 32'h0000_FF00, "R1");
        rd(2, 4'd0, 32'hFF00_0000, "R1");
        rd(0, 4'd2, 32'h0000_0000, "R1");

        // table walk on unit 0
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pend = TBL[i].pend;
            addr = TBL[i].addr;
            wdata = {24'h0, TBL[i].wdata};
            we0 = TBL[i].we;
            @(negedge clk);
            we0 = 1'b0;
            @(negedge clk);
            out(0, TBL[i].irq, TBL[i].id, {1'b0, TBL[i].prio}, $sformatf("R8 row %0d", i));
        end

        // R2 / R5 read-back of unit 0 words
        rd(0, 4'd0, 32'h0000_00FE, "R2");
        rd(0, 4'd2, 32'h0000_0005, "R5");
        rd(0, 4'd4, 32'h0000_002F, "R5");
        rd(0, 4'd5, 32'h0000_000F, "R5");

        // R11 clear address in enable style is inert
        wr(0, 4'd1, 32'h0000_0001);
        settle();
        rd(0, 4'd0, 32'h0000_00FE, "R11");
        rd(0, 4'd1, 32'h0000_0000, "R11");
        pend = 8'h80;
        settle();
        out(0, 1'b0, 3'd0, 5'd0, "R11");

        // R9 pending path takes one edge, write path takes two
        pend = 8'h10;
        settle();
        out(0, 1'b1, 3'd4, 5'd2, "R9");
        pend = 8'h20;
        settle();
        out(0, 1'b1, 3'd5, 5'd15, "R9");
        @(negedge clk);
        pend = 8'h10;
        addr = 4'd4;
        wdata = 32'h0000_003F;
        we0 = 1'b1;
        @(negedge clk);
        we0 = 1'b0;
        out(0, 1'b1, 3'd4, 5'd2, "R9");
        settle();
        out(0, 1'b1, 3'd4, 5'd3, "R9");

        // unit 1: block mask, paired priority, 16-bit words
        wr(1, 4'd0, 32'h0000_0000);
        wr(1, 4'd2, 32'h0000_0900);
        pend = 8'h02;
        settle();
        out(1, 1'b1, 3'd1, 5'd9, "R7");
        rd(1, 4'd2, 32'h0000_0900, "R10");
        wr(1, 4'd2, 32'h0000_1000);
        settle();
        rd(1, 4'd2, 32'h0000_0900, "R7");
        wr(1, 4'd4, 32'h0000_0700);
        settle();
        out(1, 1'b1, 3'd1, 5'd9, "R7");
        rd(1, 4'd4, 32'h0000_0900, "R7");
        wr(1, 4'd4, 32'h0000_0F00);
        settle();
        out(1, 1'b0, 3'd0, 5'd0, "R7");
        rd(1, 4'd2, 32'h0000_0000, "R7");
        wr(1, 4'd2, 32'h0000_0900);
        wr(1, 4'd0, 32'h0000_4000);
        settle();
        out(1, 1'b0, 3'd0, 5'd0, "R3");
        rd(1, 4'd0, 32'h0000_4000, "R3");
        wr(1, 4'd1, 32'h0000_4000);
        settle();
        rd(1, 4'd0, 32'h0000_4000, "R11");
        out(1, 1'b0, 3'd0, 5'd0, "R11");

        // unit 2: paired mask, 32-bit words, 5-bit fields
        wr(2, 4'd1, 32'h8000_0000);
        rd(2, 4'd0, 32'h7F00_0000, "R4");
        rd(2, 4'd1, 32'h7F00_0000, "R4");
        wr(2, 4'd2, 32'hF800_0008);
        rd(2, 4'd2, 32'hF800_0008, "R10");
        pend = 8'h01;
        settle();
        out(2, 1'b1, 3'd0, 5'd31, "R10");
        wr(2, 4'd3, 32'h07C0_0000);
        wr(2, 4'd1, 32'h0100_0000);
        pend = 8'h81;
        settle();
        out(2, 1'b1, 3'd0, 5'd31, "R8");
        wr(2, 4'd0, 32'h8000_0000);
        settle();
        out(2, 1'b1, 3'd7, 5'd31, "R4");
        wr(2, 4'd1, 32'h0000_0000);
        settle();
        out(2, 1'b1, 3'd7, 5'd31, "R4");
        rd(2, 4'd0, 32'hFE00_0000, "R4");
        pend = 8'h20;
        settle();
        out(2, 1'b0, 3'd0, 5'd0, "R4");
        wr(2, 4'd1, 32'h0400_0000);
        settle();
        out(2, 1'b1, 3'd5, 5'd2, "R5");
        pend = 8'h00;
        settle();
        out(2, 1'b0, 3'd0, 5'd0, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule